// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block chooses which of up to 64 interrupt slots the CPU services next. It then gives the word address of that slot's 16-bit handler vector. Each slot has one class, and the class follows from its priority number. The top slot is a reset source, and no enable bit can gate it. The two slots below it are non-maskable: their own enable bit can gate them, but the global enable cannot. A band of maskable slots follows, and each needs both its own enable and the global enable. The slots below the populated band are reserved and never raise a request.

The winning slot is registered. The request, the slot number and the vector address then stay steady while the CPU fetches the handler. When the CPU pulses its acknowledge, the block sends a one-cycle clear to the winning slot only. It drops its request for one cycle and then arbitrates again. The reset slot does not wait for an acknowledge. It replaces any held winner on the next cycle and raises a separate reset request.

Top module: `irq_vector_arbiter`

## Requirements
- R1: The vector address equals 0xFF80 plus twice the slot number, so bit 0 is always 0. Slot 63 maps to 0xFFFE and slot 44 maps to 0xFFD8.
- R2: When slot 63 is pending, it wins on the next clock edge whatever the enables are, even over a held winner. While slot 63 is the registered winner, `reset_req_o` is 1.
- R3: Slots 62 and 61 are eligible when their pending bit and their own enable bit are both 1. The global enable has no effect on them.
- R4: Slots 44 through 60 are eligible only when the pending bit, the slot's enable bit and `gie_i` are all 1.
- R5: Slots 0 through 43 never produce a request, whatever their pending and enable bits are.
- R6: When several eligible slots are pending, the one with the highest slot number wins.
- R7: An eligible request shows on `req_o`, `slot_o` and `vec_o` one clock edge after it is presented. Until acknowledged, these hold steady, and a new higher maskable or non-maskable request does not change them.
- R8: During a cycle with `ack_i`=1 and `req_o`=1, `clear_o` is one-hot with bit `slot_o` set. In every other cycle, `clear_o` is zero.
- R9: After an acknowledge edge, `req_o` is 0 for one cycle. On the following edge, the highest eligible slot still pending is captured.
- R10: A synchronous active-high `rst` clears `req_o`, `reset_req_o` and `slot_o`, which leaves `vec_o` at 0xFF80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | 64 | Pending line per slot, indexed by priority number |
| ien_i | input | 64 | Individual enable per slot |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | CPU acknowledge strobe |
| req_o | output | 1 | Interrupt request to the CPU |
| slot_o | output | 6 | Registered winning slot number |
| vec_o | output | 16 | Word address of the winner's vector |
| reset_req_o | output | 1 | Reset request, high while slot 63 is the winner |
| clear_o | output | 64 | One-cycle clear to the acknowledged slot |

## Verification
The bench targets the class boundaries.

- A slot 61 request with the global enable low must still win. A design that mixed up the classes would leave it silent.
- A slot 60 request in the same case must stay blocked.
- Reserved slot 43 and the slots below it must stay quiet even with every enable set. An off-by-one in the populated band would raise a request with a vector below 0xFFD8.

It also raises a higher request while a winner is held. A design that re-arbitrates without an acknowledge would change `slot_o` and give the CPU a torn vector. A reset pending with all enables clear must replace the held winner at once. Finally, the clear pulse is checked to be one-hot and aligned to the acknowledge cycle, since a misplaced clear would drop an unrelated peripheral's flag.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int VEC_W = 16;

  typedef enum logic [1:0] {
    CLS_RSVD  = 2'd0,
    CLS_RESET = 2'd1,
    CLS_NMI   = 2'd2,
    CLS_MASK  = 2'd3
  } irq_class_e;

  // Class of a slot from its priority number.
  function automatic irq_class_e slot_class(int idx, int top_slot, int nmi_lo, int pop_lo);
    if (idx == top_slot)     return CLS_RESET;
    else if (idx >= nmi_lo)  return CLS_NMI;
    else if (idx >= pop_lo)  return CLS_MASK;
    else                     return CLS_RSVD;
  endfunction

  // Vector word address: base plus two bytes per priority step.
  function automatic logic [VEC_W-1:0] vec_addr(logic [VEC_W-1:0] base, int unsigned slot);
    return base + VEC_W'(slot << 1);
  endfunction

endpackage

// File: rtl/irq_eligible.sv
module irq_eligible
  import irq_vec_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int NMI_LO    = 61,
  parameter int POP_LO    = 44
) (
  input  logic [NUM_SLOTS-1:0] pend_i,
  input  logic [NUM_SLOTS-1:0] ien_i,
  input  logic                 gie_i,
  output logic [NUM_SLOTS-1:0] elig_o
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam irq_class_e CLS = slot_class(g, NUM_SLOTS-1, NMI_LO, POP_LO);
    if (CLS == CLS_RESET) begin : g_rst
      assign elig_o[g] = pend_i[g];
    end else if (CLS == CLS_NMI) begin : g_nmi
      assign elig_o[g] = pend_i[g] & ien_i[g];
    end else if (CLS == CLS_MASK) begin : g_msk
      assign elig_o[g] = pend_i[g] & ien_i[g] & gie_i;
    end else begin : g_rsv
      assign elig_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] elig_i,
  output logic                 valid_o,
  output logic [SLOT_W-1:0]    idx_o
);

  // Ascending scan: the last hit is the highest number.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (elig_i[i]) begin
        valid_o = 1'b1;
        idx_o   = SLOT_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_winner_reg.sv
module irq_winner_reg #(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid_i,
  input  logic [SLOT_W-1:0] win_idx_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              reset_req_o
);

  localparam logic [SLOT_W-1:0] RST_SLOT = SLOT_W'(NUM_SLOTS-1);

  logic reset_win;
  logic take;
  logic ack_evt;

  assign reset_win = win_valid_i && (win_idx_i == RST_SLOT);
  assign ack_evt   = req_o && ack_i;
  assign take      = reset_win || (!req_o && win_valid_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o       <= 1'b0;
      slot_o      <= '0;
      reset_req_o <= 1'b0;
    end else if (take) begin
      req_o       <= 1'b1;
      slot_o      <= win_idx_i;
      reset_req_o <= reset_win;
    end else if (ack_evt) begin
      req_o       <= 1'b0;
      reset_req_o <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_vec_pkg::*;
#(
  parameter int                NUM_SLOTS = 64,
  parameter int                NMI_LO    = 61,
  parameter int                POP_LO    = 44,
  parameter logic [VEC_W-1:0]  VEC_BASE  = 16'hFF80,
  parameter int                SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] pend_i,
  input  logic [NUM_SLOTS-1:0] ien_i,
  input  logic                 gie_i,
  input  logic                 ack_i,
  output logic                 req_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 reset_req_o,
  output logic [NUM_SLOTS-1:0] clear_o
);

  logic [NUM_SLOTS-1:0] elig;
  logic                 win_valid;
  logic [SLOT_W-1:0]    win_idx;
  logic                 ack_evt;

  irq_eligible #(.NUM_SLOTS(NUM_SLOTS), .NMI_LO(NMI_LO), .POP_LO(POP_LO)) u_elig (
    .pend_i (pend_i),
    .ien_i  (ien_i),
    .gie_i  (gie_i),
    .elig_o (elig)
  );

  irq_prio_enc #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_enc (
    .elig_i  (elig),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  irq_winner_reg #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_win (
    .clk         (clk),
    .rst         (rst),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .ack_i       (ack_i),
    .req_o       (req_o),
    .slot_o      (slot_o),
    .reset_req_o (reset_req_o)
  );

  assign ack_evt = req_o && ack_i;
  assign vec_o   = vec_addr(VEC_BASE, 32'(slot_o));

  always_comb begin
    clear_o = '0;
    if (ack_evt) clear_o[slot_o] = 1'b1;
  end

endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk #(
  parameter int NUM_SLOTS = 64,
  parameter int POP_LO    = 44,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_SLOTS-1:0] pend_i,
  input logic                 ack_i,
  input logic                 req_o,
  input logic [SLOT_W-1:0]    slot_o,
  input logic [15:0]          vec_o,
  input logic                 reset_req_o,
  input logic [NUM_SLOTS-1:0] clear_o,
  input logic                 win_valid
);

  localparam logic [SLOT_W-1:0] RST_SLOT = SLOT_W'(NUM_SLOTS-1);

  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    vec_o[0] == 1'b0 && vec_o >= 16'hFF80); // R1

  AST_RESET_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    pend_i[NUM_SLOTS-1] |=> req_o && slot_o == RST_SLOT && reset_req_o); // R2

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
    req_o |-> slot_o >= SLOT_W'(POP_LO)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    req_o && !ack_i && !pend_i[NUM_SLOTS-1] |=> req_o && $stable(slot_o)); // R7

  AST_IDLE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !req_o && win_valid |=> req_o); // R7

  AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clear_o) && ((clear_o != '0) == (req_o && ack_i))); // R8

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    req_o && ack_i && !pend_i[NUM_SLOTS-1] |=> !req_o); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !req_o && !reset_req_o && slot_o == '0); // R10

endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .POP_LO    (POP_LO),
  .SLOT_W    (SLOT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pend_i      (pend_i),
  .ack_i       (ack_i),
  .req_o       (req_o),
  .slot_o      (slot_o),
  .vec_o       (vec_o),
  .reset_req_o (reset_req_o),
  .clear_o     (clear_o),
  .win_valid   (win_valid)
);

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] pend_i;
  logic [63:0] ien_i;
  logic        gie_i;
  logic        ack_i;
  logic        req_o;
  logic [5:0]  slot_o;
  logic [15:0] vec_o;
  logic        reset_req_o;
  logic [63:0] clear_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_vector_arbiter u_dut (
    .clk(clk), .rst(rst), .pend_i(pend_i), .ien_i(ien_i), .gie_i(gie_i),
    .ack_i(ack_i), .req_o(req_o), .slot_o(slot_o), .vec_o(vec_o),
    .reset_req_o(reset_req_o), .clear_o(clear_o)
  );

  function automatic logic [15:0] exp_vec(int s);
    return 16'hFF80 + 16'(2 * s);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1; pend_i = '0; ien_i = '0; gie_i = 1'b0; ack_i = 1'b0;
    edge_n(2);
    rst = 1'b0;
  endtask

  task automatic expect_win(string req, int s);
    chk(req, {63'd0, req_o}, 64'd1);
    chk(req, {58'd0, slot_o}, 64'(s));
    chk(req, {48'd0, vec_o}, 64'(exp_vec(s)));
  endtask

  task automatic t_reset_state;
    do_reset();
    chk("R10 req", {63'd0, req_o}, 64'd0);
    chk("R10 rstreq", {63'd0, reset_req_o}, 64'd0);
    chk("R10 vec", {48'd0, vec_o}, 64'hFF80);
    chk("R8 idle clear", clear_o, 64'd0);
  endtask

  task automatic t_maskable;
    do_reset();
    pend_i[50] = 1'b1; ien_i[50] = 1'b1; gie_i = 1'b0;
    edge_n(1);
    chk("R4 gie low blocks", {63'd0, req_o}, 64'd0);
    gie_i = 1'b1; ien_i[50] = 1'b0;
    edge_n(1);
    chk("R4 ien low blocks", {63'd0, req_o}, 64'd0);
    ien_i[50] = 1'b1;
    edge_n(1);
    expect_win("R4 R1 R7 slot50", 50);
  endtask

  task automatic t_nmi;
    do_reset();
    pend_i[61] = 1'b1; ien_i[61] = 1'b1; gie_i = 1'b0;
    pend_i[60] = 1'b1; ien_i[60] = 1'b1;
    edge_n(1);
    expect_win("R3 nmi ignores gie", 61);
    do_reset();
    pend_i[62] = 1'b1; ien_i[62] = 1'b0; gie_i = 1'b1;
    edge_n(1);
    chk("R3 nmi own enable", {63'd0, req_o}, 64'd0);
  endtask

  task automatic t_reserved;
    do_reset();
    pend_i = 64'h0000_0FFF_FFFF_FFFF; ien_i = '1; gie_i = 1'b1;
    edge_n(2);
    chk("R5 reserved silent", {63'd0, req_o}, 64'd0);
    pend_i[44] = 1'b1;
    edge_n(1);
    expect_win("R5 R1 lowest populated", 44);
  endtask

  task automatic t_priority;
    do_reset();
    ien_i = '1; gie_i = 1'b1;
    pend_i[45] = 1'b1; pend_i[55] = 1'b1; pend_i[60] = 1'b1;
    edge_n(1);
    expect_win("R6 highest wins", 60);
  endtask

  task automatic t_hold_ack;
    do_reset();
    ien_i = '1; gie_i = 1'b1;
    pend_i[55] = 1'b1;
    edge_n(1);
    expect_win("R7 capture", 55);
    pend_i[60] = 1'b1; pend_i[62] = 1'b1;
    edge_n(2);
    expect_win("R7 held", 55);
    ack_i = 1'b1;
    #1;
    chk("R8 clear onehot", clear_o, 64'd1 << 55);
    edge_n(1);
    ack_i = 1'b0; pend_i[55] = 1'b0;
    chk("R9 drop", {63'd0, req_o}, 64'd0);
    chk("R8 clear gone", clear_o, 64'd0);
    edge_n(1);
    expect_win("R9 rearbitrate", 62);
  endtask

  task automatic t_reset_slot;
    do_reset();
    ien_i = '1; gie_i = 1'b1;
    pend_i[58] = 1'b1;
    edge_n(1);
    expect_win("R7 pre", 58);
    ien_i = '0; gie_i = 1'b0; pend_i[63] = 1'b1;
    edge_n(1);
    expect_win("R2 override", 63);
    chk("R2 rstreq", {63'd0, reset_req_o}, 64'd1);
    chk("R1 top vec", {48'd0, vec_o}, 64'hFFFE);
    rst = 1'b1;
    edge_n(1);
    rst = 1'b0; pend_i = '0;
    chk("R10 clears", {62'd0, req_o, reset_req_o}, 64'd0);
  endtask

  task automatic t_vec_sweep;
    for (int s = 44; s <= 60; s++) begin
      do_reset();
      ien_i = '1; gie_i = 1'b1; pend_i[s] = 1'b1;
      edge_n(1);
      chk("R1 sweep vec", {48'd0, vec_o}, 64'(exp_vec(s)));
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pend_i = '0; ien_i = '0; gie_i = 1'b0; ack_i = 1'b0;
    edge_n(1);
    t_reset_state();
    t_maskable();
    t_nmi();
    t_reserved();
    t_priority();
    t_hold_ack();
    t_reset_slot();
    t_vec_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule